// File: doc/BRIEF.md
# Indexed Real-Time Clock Register File

The block gives a bus master access to a small real-time-clock register file through two 8-bit ports. The master first writes an index through the address port and then reads or writes the selected register through the data port. Indices 0x00 to 0x09 select plain time-of-day storage bytes. Indices 0x0A to 0x0D select four status registers, and each of those has its own restricted behaviour. A host time-set port loads the calendar bytes in one cycle.

Status register A is fixed to a single legal value. Its update-in-progress bit flips on every read, so polling software always sees it change. Status register B enables or disables a periodic interrupt generator, which pulses `irq_o` once every `PERIOD_CYC` clock cycles while it runs. Registers C and D read as zero. Any access the block does not support is rejected: it raises a one-cycle `err_o` pulse and leaves all state unchanged.

Top module: `rtc_index_regs`

## Requirements
- R1: An index write of 0x00 to 0x0D is latched without error. An index write above 0x0D raises `err_o` and keeps the previous index.
- R2: Indices 0x00 to 0x09 address storage bytes that hold any written value. A data read returns the selected byte on `rdata_o` one cycle after the read strobe, and `rdata_o` holds that value until the next accepted read.
- R3: A `host_set_i` pulse loads bytes 0, 2, 4, 6, 7, 8 and 9 with seconds, minutes, hours, weekday+1, day of month, month+1 and year. Bytes 1, 3 and 5 keep their contents.
- R4: Register A (index 0x0A) resets to 0x26. A write of exactly 0x26 is accepted. Any other value raises `err_o` and leaves A unchanged.
- R5: Each read of register A inverts bit 7 and returns the inverted value, so the first read after reset returns 0xA6.
- R6: Register B (index 0x0B) resets to 0x46. A write is accepted only when the value with bits 6 and 3 masked equals 0x06. Any other value raises `err_o` and leaves B unchanged.
- R7: While the periodic timer runs, `irq_o` is a one-cycle pulse. The first pulse comes `PERIOD_CYC` cycles after the starting write, and later pulses follow every `PERIOD_CYC` cycles. The timer runs from reset.
- R8: An accepted B write with bit 6 set starts the timer only if it is idle. If the timer is already running, its phase is kept. An accepted B write with bit 6 clear stops the timer at once, and no pulse follows.
- R9: Registers C and D (0x0C, 0x0D) read as 0x00. Writes to them raise `err_o` and change nothing.
- R10: When several strobes coincide, the address write wins over the data write, and the data write wins over the data read. The losing strobes have no effect. `err_o` pulses for one cycle, in the cycle after the rejected strobe, and is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_wr_i | input | 1 | Index port write strobe |
| data_wr_i | input | 1 | Data port write strobe |
| data_rd_i | input | 1 | Data port read strobe |
| wdata_i | input | 8 | Write data for index and data ports |
| rdata_o | output | 8 | Registered read data |
| err_o | output | 1 | One-cycle pulse on a rejected access |
| irq_o | output | 1 | Periodic interrupt pulse |
| host_set_i | input | 1 | Load calendar bytes from the set inputs |
| set_sec_i | input | 8 | Seconds to load |
| set_min_i | input | 8 | Minutes to load |
| set_hour_i | input | 8 | Hours to load |
| set_wday_i | input | 8 | Weekday, zero-based |
| set_mday_i | input | 8 | Day of month |
| set_mon_i | input | 8 | Month, zero-based |
| set_year_i | input | 8 | Year |

## Verification
The bench builds the block with `PERIOD_CYC` set to 12, so several interrupt periods fit in a few dozen cycles. With that setting the bench can check pulse spacing exactly, confirm that a mid-period re-enable keeps the phase, and confirm silence after a stop. All 256 index values, all 256 writes to A and all 256 writes to B are swept, with the acceptance rule for each computed arithmetically. The host set is tried at the weekday and month extremes.

// File: rtl/rtc_idx_pkg.sv
package rtc_idx_pkg;
  localparam int unsigned DW        = 8;
  localparam int unsigned IDX_W     = 4;
  localparam int unsigned NUM_STORE = 10;

  localparam logic [DW-1:0]    IDX_MAX = 8'h0D;
  localparam logic [IDX_W-1:0] REG_A   = 4'hA;
  localparam logic [IDX_W-1:0] REG_B   = 4'hB;
  localparam logic [IDX_W-1:0] REG_C   = 4'hC;

  localparam logic [DW-1:0] A_INIT = 8'h26;
  localparam logic [DW-1:0] A_UIP  = 8'h80;

  localparam int unsigned   B_PIE   = 6;
  localparam logic [DW-1:0] B_INIT  = 8'h46;
  localparam logic [DW-1:0] B_FREE  = 8'h48;   // periodic enable, square wave enable
  localparam logic [DW-1:0] B_FIXED = 8'h06;   // binary, 24-hour

  localparam int unsigned IX_SEC  = 0;
  localparam int unsigned IX_MIN  = 2;
  localparam int unsigned IX_HOUR = 4;
  localparam int unsigned IX_WDAY = 6;
  localparam int unsigned IX_MDAY = 7;
  localparam int unsigned IX_MON  = 8;
  localparam int unsigned IX_YEAR = 9;
  localparam logic [NUM_STORE-1:0] HOST_MASK = 10'b11_1101_0101;
endpackage

// File: rtl/rtc_idx_decode.sv
module rtc_idx_decode
  import rtc_idx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             bad_o
);
  logic [IDX_W-1:0] idx_q;

  assign bad_o = wr_i && (wdata_i > IDX_MAX);
  assign idx_o = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              idx_q <= '0;
    else if (wr_i && !bad_o)  idx_q <= wdata_i[IDX_W-1:0];
  end

  AST_IDX_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i > IDX_MAX) |=> $stable(idx_q)); // R1
  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {4'h0, idx_q} <= IDX_MAX); // R1
endmodule

// File: rtl/rtc_clock_store.sv
module rtc_clock_store
  import rtc_idx_pkg::*;
#(
  parameter int unsigned N = NUM_STORE
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic                 host_set_i,
  input  logic [N-1:0]         host_mask_i,
  input  logic [N-1:0][DW-1:0] host_bytes_i,
  output logic [DW-1:0]        rdata_o
);
  logic [N-1:0][DW-1:0] mem_q;

  for (genvar g = 0; g < N; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem_q[g] <= '0;
      else if (host_set_i && host_mask_i[g]) mem_q[g] <= host_bytes_i[g];
      else if (wr_i && idx_i == IDX_W'(g))  mem_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N; i++)
      if (idx_i == IDX_W'(i)) rdata_o = mem_q[i];
  end
endmodule

// File: rtl/rtc_periodic_timer.sv
module rtc_periodic_timer #(
  parameter int unsigned PERIOD_CYC = 1000,
  parameter bit          RUN_INIT   = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  output logic irq_o
);
  localparam int unsigned CW = $clog2(PERIOD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

  logic          run_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= RUN_INIT;
      cnt_q <= '0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= run_q && !stop_i && (cnt_q == LAST);
      if (stop_i) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else if (start_i && !run_q) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end else if (run_q) begin
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
    end
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R7
  AST_IRQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |=> !irq_o); // R8
  AST_IRQ_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !run_q && !irq_o); // R8
endmodule

// File: rtl/rtc_index_regs.sv
module rtc_index_regs
  import rtc_idx_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          addr_wr_i,
  input  logic          data_wr_i,
  input  logic          data_rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          err_o,
  output logic          irq_o,
  input  logic          host_set_i,
  input  logic [DW-1:0] set_sec_i,
  input  logic [DW-1:0] set_min_i,
  input  logic [DW-1:0] set_hour_i,
  input  logic [DW-1:0] set_wday_i,
  input  logic [DW-1:0] set_mday_i,
  input  logic [DW-1:0] set_mon_i,
  input  logic [DW-1:0] set_year_i
);
  logic                         do_idx, do_wr, do_rd;
  logic [IDX_W-1:0]             idx;
  logic                         idx_bad;
  logic [DW-1:0]                st_rdata;
  logic [NUM_STORE-1:0][DW-1:0] host_bytes;
  logic                         sel_st, sel_a, sel_b, sel_cd;
  logic                         a_ok, b_ok, err_d;
  logic [DW-1:0]                stat_a, stat_b;

  // strobe priority: index > data write > data read
  assign do_idx = addr_wr_i;
  assign do_wr  = data_wr_i && !addr_wr_i;
  assign do_rd  = data_rd_i && !addr_wr_i && !data_wr_i;

  rtc_idx_decode u_idx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (do_idx),
    .wdata_i(wdata_i),
    .idx_o  (idx),
    .bad_o  (idx_bad)
  );

  assign sel_st = idx < REG_A;
  assign sel_a  = idx == REG_A;
  assign sel_b  = idx == REG_B;
  assign sel_cd = idx >= REG_C;

  always_comb begin
    host_bytes          = '0;
    host_bytes[IX_SEC]  = set_sec_i;
    host_bytes[IX_MIN]  = set_min_i;
    host_bytes[IX_HOUR] = set_hour_i;
    host_bytes[IX_WDAY] = set_wday_i + 8'd1;
    host_bytes[IX_MDAY] = set_mday_i;
    host_bytes[IX_MON]  = set_mon_i + 8'd1;
    host_bytes[IX_YEAR] = set_year_i;
  end

  rtc_clock_store #(.N(NUM_STORE)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (do_wr && sel_st),
    .idx_i       (idx),
    .wdata_i     (wdata_i),
    .host_set_i  (host_set_i),
    .host_mask_i (HOST_MASK),
    .host_bytes_i(host_bytes),
    .rdata_o     (st_rdata)
  );

  assign a_ok  = wdata_i == A_INIT;
  assign b_ok  = (wdata_i & ~B_FREE) == B_FIXED;
  assign err_d = idx_bad
               | (do_wr && sel_a && !a_ok)
               | (do_wr && sel_b && !b_ok)
               | (do_wr && sel_cd);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_a  <= A_INIT;
      stat_b  <= B_INIT;
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= err_d;
      if (do_wr && sel_a && a_ok)  stat_a <= A_INIT;
      else if (do_rd && sel_a)     stat_a <= stat_a ^ A_UIP;
      if (do_wr && sel_b && b_ok)  stat_b <= wdata_i;
      if (do_rd) begin
        if (sel_st)      rdata_o <= st_rdata;
        else if (sel_a)  rdata_o <= stat_a ^ A_UIP;
        else if (sel_b)  rdata_o <= stat_b;
        else             rdata_o <= '0;
      end
    end
  end

  rtc_periodic_timer #(.PERIOD_CYC(PERIOD_CYC), .RUN_INIT(B_INIT[B_PIE])) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(do_wr && sel_b && b_ok && wdata_i[B_PIE]),
    .stop_i (do_wr && sel_b && b_ok && !wdata_i[B_PIE]),
    .irq_o  (irq_o)
  );

  AST_A_UIP_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_rd && sel_a) |=> stat_a[7] != $past(stat_a[7])); // R5
  AST_A_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_wr && sel_a && wdata_i != A_INIT) |=> $stable(stat_a) && err_o); // R4
  AST_B_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_wr && sel_b && (wdata_i & ~B_FREE) != B_FIXED) |=> $stable(stat_b) && err_o); // R6
  AST_CD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_rd && sel_cd) |=> rdata_o == '0); // R9
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !do_rd |=> $stable(rdata_o)); // R10
endmodule

// File: tb/tb_rtc_index_regs.sv
module tb_rtc_index_regs;
  localparam int P = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_wr = 0, data_wr = 0, data_rd = 0, host_set = 0;
  logic [7:0] wdata = 0;
  logic [7:0] s_sec = 0, s_min = 0, s_hour = 0, s_wday = 0, s_mday = 0, s_mon = 0, s_year = 0;
  logic [7:0] rdata;
  logic       err, irq;

  int vec = 0, bad = 0;
  int cyc = 0, start_cyc = 0, mon_mode = 0, pulses = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rtc_index_regs #(.PERIOD_CYC(P)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_wr_i(addr_wr), .data_wr_i(data_wr),
    .data_rd_i(data_rd), .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .irq_o(irq),
    .host_set_i(host_set), .set_sec_i(s_sec), .set_min_i(s_min), .set_hour_i(s_hour),
    .set_wday_i(s_wday), .set_mday_i(s_mday), .set_mon_i(s_mon), .set_year_i(s_year)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic op(input logic a, input logic d, input logic r, input logic [7:0] v);
    @(negedge clk);
    addr_wr = a; data_wr = d; data_rd = r; wdata = v;
    @(negedge clk);
    addr_wr = 0; data_wr = 0; data_rd = 0;
  endtask

  task automatic set_idx(input logic [7:0] v); op(1, 0, 0, v); endtask
  task automatic wr(input logic [7:0] v);      op(0, 1, 0, v); endtask
  task automatic rd;                           op(0, 0, 1, 8'h00); endtask

  // R7 R8 monitor sampled 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (mon_mode == 1) begin
      chk("R7", {7'b0, irq}, {7'b0, (cyc > start_cyc) && ((cyc - start_cyc) % P == 0)});
      if (irq) pulses++;
    end else if (mon_mode == 2) begin
      chk("R8", {7'b0, irq}, 8'h00);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vec++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_b;
    logic [7:0] hold;
    logic       ub;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset rdata", rdata, 8'h00);
    chk("R10 reset err", {7'b0, err}, 8'h00);

    // R2: all storage bytes, then full data sweep on byte 0
    for (int i = 0; i < 10; i++) begin set_idx(8'(i)); wr(8'(8'h30 + i * 7)); end
    for (int i = 0; i < 10; i++) begin
      set_idx(8'(i)); rd;
      chk("R2 byte", rdata, 8'(8'h30 + i * 7));
    end
    set_idx(8'h00);
    for (int v = 0; v < 256; v++) begin
      wr(8'(v)); chk("R2 err", {7'b0, err}, 8'h00);
      rd; chk("R2 sweep", rdata, 8'(v));
    end

    // R1: index sweep, rejected index keeps index 3
    set_idx(8'h03); wr(8'h5A);
    for (int v = 0; v < 256; v++) begin
      set_idx(8'h03);
      set_idx(8'(v));
      chk("R1 err", {7'b0, err}, {7'b0, v > 13});
      if (v > 13) begin rd; chk("R1 keep", rdata, 8'h5A); end
    end

    // R9: C and D
    for (int r = 12; r < 14; r++) begin
      set_idx(8'(r)); rd; chk("R9 read", rdata, 8'h00);
      wr(8'hFF); chk("R9 err", {7'b0, err}, 8'h01);
      rd; chk("R9 read after write", rdata, 8'h00);
    end

    // R4 R5: register A
    set_idx(8'h0A); ub = 1'b0;
    for (int k = 0; k < 4; k++) begin
      rd; ub = ~ub; chk("R5 toggle", rdata, {ub, 7'h26});
    end
    for (int v = 0; v < 256; v++) begin
      wr(8'(v));
      chk("R4 err", {7'b0, err}, {7'b0, v != 8'h26});
      if (v == 8'h26) ub = 1'b0;
      rd; ub = ~ub; chk("R4 value", rdata, {ub, 7'h26});
    end

    // R6: register B
    set_idx(8'h0B); rd; chk("R6 reset", rdata, 8'h46);
    exp_b = 8'h46;
    for (int v = 0; v < 256; v++) begin
      wr(8'(v));
      chk("R6 err", {7'b0, err}, {7'b0, (8'(v) & 8'hB7) != 8'h06});
      if ((8'(v) & 8'hB7) == 8'h06) exp_b = 8'(v);
      rd; chk("R6 value", rdata, exp_b);
    end
    wr(8'h06); chk("R8 stop accepted", {7'b0, err}, 8'h00);

    // R7 R8: start from idle, re-enable mid-period, stop
    wr(8'h46);
    start_cyc = cyc; mon_mode = 1;
    repeat (2 * P + 5) @(negedge clk);
    wr(8'h4E);
    repeat (2 * P) @(negedge clk);
    mon_mode = 0;
    chk("R7 pulse count", 8'(pulses), 8'd4);
    wr(8'h0E);
    mon_mode = 2;
    repeat (3 * P) @(negedge clk);
    mon_mode = 0;

    // R3: host set, alarm bytes retained
    for (int i = 1; i < 6; i += 2) begin set_idx(8'(i)); wr(8'(8'hA0 + i)); end
    for (int pass = 0; pass < 2; pass++) begin
      logic [7:0] e [10];
      s_sec = 8'd59; s_min = 8'd45; s_hour = 8'd23; s_mday = 8'd31; s_year = 8'd99;
      s_wday = pass ? 8'd0 : 8'd6; s_mon = pass ? 8'd0 : 8'd11;
      if (pass) begin s_sec = 8'd0; s_min = 8'd0; s_hour = 8'd0; s_mday = 8'd1; s_year = 8'd70; end
      @(negedge clk); host_set = 1'b1;
      @(negedge clk); host_set = 1'b0;
      e[0] = s_sec; e[1] = 8'hA1; e[2] = s_min; e[3] = 8'hA3; e[4] = s_hour;
      e[5] = 8'hA5; e[6] = s_wday + 8'd1; e[7] = s_mday; e[8] = s_mon + 8'd1; e[9] = s_year;
      for (int i = 0; i < 10; i++) begin
        set_idx(8'(i)); rd; chk("R3 host byte", rdata, e[i]);
      end
    end

    // R10: strobe priority
    set_idx(8'h02); wr(8'h22);
    hold = rdata;
    op(1, 1, 1, 8'h05);
    chk("R10 idx wins rdata", rdata, hold);
    chk("R10 idx wins err", {7'b0, err}, 8'h00);
    rd; chk("R10 idx applied", rdata, 8'hA5);
    set_idx(8'h02); rd; chk("R10 data not written", rdata, 8'h22);
    hold = rdata;
    op(0, 1, 1, 8'h33);
    chk("R10 write over read", rdata, hold);
    rd; chk("R10 write applied", rdata, 8'h33);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule